// File: doc/BRIEF.md
# Stacked Time-Division Link with Divided Receive Enable

This block carries a wide system word across a narrow lane. The lane moves one slot of `W` bits on every link clock and never pauses. Two multiplexing layers share the job. The soft layer works at system rate and cuts the word into `SOFT` soft slots. The hard layer cuts each soft slot into `HARD` lane pieces. One frame therefore lasts `N = SOFT * HARD` link clocks. The transmitter raises a load strobe once per frame and captures the next word on that edge. The first piece of every frame carries a frame marker.

The receiver has no handshake. It follows the forwarded lane and uses the marker to set its slot counter. It gathers all `N` pieces and presents the rebuilt word for one cycle. It also derives its own system-rate clock enable by dividing the link clock by the hard ratio, locked in phase to the marker. A divider ratio from 1 to 16 is supported. A build option removes the receive input register, which shortens the path by one link clock.

Top module: `tdm_link`

## Requirements
- R1: During and directly after a synchronous reset, every output is 0. The frame position restarts, so the first `tx_load` pulse falls in the N-th cycle after reset is released.
- R2: `tx_load` is high for exactly one cycle in every N, with N = SOFT*HARD. `tx_word` is captured at the rising edge that ends a cycle in which `tx_load` is high.
- R3: The lane never stalls. Lane slot s carries `tx_word[s*W +: W]`, where s = soft index * HARD + hard index. Slot s is on `link_data` in the cycle s+2 after the load cycle. Before the first word, `link_data` is 0.
- R4: `link_mark` is high exactly in the cycle that shows slot 0 of a loaded word, and low in every other cycle.
- R5: `rx_sys_en` is a one-cycle clock-enable pulse. Once it starts, it repeats every HARD link cycles with no gaps, and it is phase-locked to the received marker. With HARD = 1 it is high on every cycle.
- R6: `rx_valid` pulses for one cycle for each loaded word. `rx_word` then equals that word, and the pulse always coincides with an `rx_sys_en` pulse.
- R7: `rx_valid` rises N+3 cycles after the load cycle when `FAST_RX` = 0, and N+2 cycles after it when `FAST_RX` = 1. The option therefore saves exactly one link cycle.
- R8: Until the first marker has reached the receiver, `rx_valid` and `rx_sys_en` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_word | input | SOFT*HARD*W | System word to send |
| tx_load | output | 1 | High in the cycle whose closing edge captures `tx_word` |
| link_data | output | W | Lane slot driven by the hard multiplexer |
| link_mark | output | 1 | Frame marker, high with slot 0 |
| rx_word | output | SOFT*HARD*W | Rebuilt word |
| rx_valid | output | 1 | One-cycle strobe for `rx_word` |
| rx_sys_en | output | 1 | Receive system-rate enable, link clock divided by HARD |

## Verification
Two events share the same clock edge. On the load edge, the soft stage takes soft slot 0 straight from `tx_word`, while the hard stage is still sending the last piece of the previous word's final soft slot. The bench provokes this with back-to-back frames in which `tx_word` changes on every cycle. A slot taken from the wrong word would therefore show up at once, both in the per-slot comparison on the lane and in the rebuilt word. The same stream also makes the end of reassembly land on a divider pulse. The bench judges this by requiring every `rx_valid` to coincide with `rx_sys_en` and to arrive at the exact latency for each build.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;
  // width of a counter that has to hold the values 0 .. n-1
  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tdm_tx_soft.sv
module tdm_tx_soft #(
  parameter int W    = 8,
  parameter int HARD = 2,
  parameter int SOFT = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SOFT*HARD*W-1:0]   word_i,
  output logic                     load_o,
  output logic [tdm_link_pkg::cnt_w(HARD)-1:0] hard_ph_o,
  output logic [HARD*W-1:0]        slot_o,
  output logic                     first_o
);
  localparam int SW  = HARD * W;
  localparam int NW  = SOFT * SW;
  localparam int HCW = tdm_link_pkg::cnt_w(HARD);
  localparam int SCW = tdm_link_pkg::cnt_w(SOFT);

  logic [HCW-1:0] hard_ph;
  logic [SCW-1:0] soft_ph;
  logic [SCW-1:0] soft_nxt;
  logic [NW-1:0]  hold;
  logic           sys_last;
  logic           frame_last;

  assign sys_last   = (hard_ph == HCW'(HARD - 1));
  assign frame_last = sys_last && (soft_ph == SCW'(SOFT - 1));
  assign soft_nxt   = (soft_ph == SCW'(SOFT - 1)) ? '0 : soft_ph + 1'b1;
  assign load_o     = frame_last;
  assign hard_ph_o  = hard_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      hard_ph <= '0;
      soft_ph <= '0;
      hold    <= '0;
      slot_o  <= '0;
      first_o <= 1'b0;
    end else begin
      hard_ph <= sys_last ? '0 : hard_ph + 1'b1;
      if (sys_last) begin
        soft_ph <= soft_nxt;
        first_o <= frame_last;
        // the load edge feeds soft slot 0 straight from the input word
        if (frame_last) slot_o <= word_i[SW-1:0];
        else            slot_o <= hold[soft_nxt*SW +: SW];
      end
      if (frame_last) hold <= word_i;
    end
  end
endmodule

// File: rtl/tdm_tx_hard.sv
module tdm_tx_hard #(
  parameter int W    = 8,
  parameter int HARD = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [HARD*W-1:0]                     slot_i,
  input  logic                                  first_i,
  input  logic [tdm_link_pkg::cnt_w(HARD)-1:0]  hard_ph_i,
  output logic [W-1:0]                          lane_o,
  output logic                                  mark_o
);
  localparam int HCW = tdm_link_pkg::cnt_w(HARD);

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_o <= '0;
      mark_o <= 1'b0;
    end else begin
      lane_o <= slot_i[hard_ph_i*W +: W];
      mark_o <= first_i && (hard_ph_i == HCW'(0));
    end
  end
endmodule

// File: rtl/tdm_clk_en_div.sv
module tdm_clk_en_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic en_o
);
  localparam int DW = tdm_link_pkg::cnt_w(DIV);

  logic [DW-1:0] ph;
  logic [DW-1:0] cur;
  logic          locked;
  logic          at_end;

  assign cur    = sync_i ? '0 : ph;
  assign at_end = (cur == DW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      locked <= 1'b0;
      en_o   <= 1'b0;
    end else if (sync_i || locked) begin
      locked <= 1'b1;
      en_o   <= at_end;
      ph     <= at_end ? '0 : cur + 1'b1;
    end else begin
      en_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_rx_asm.sv
module tdm_rx_asm #(
  parameter int W = 8,
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   data_i,
  input  logic           mark_i,
  output logic [N*W-1:0] word_o,
  output logic           valid_o
);
  localparam int RCW = tdm_link_pkg::cnt_w(N);

  logic [RCW-1:0] rcnt;
  logic [RCW-1:0] cur;
  logic           locked;
  logic           active;
  logic           last;
  logic [N*W-1:0] asmb;
  logic [N*W-1:0] full;

  assign cur    = mark_i ? '0 : rcnt;
  assign active = mark_i || locked;
  assign last   = (cur == RCW'(N - 1));

  always_comb begin
    full = asmb;
    full[(N-1)*W +: W] = data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt    <= '0;
      locked  <= 1'b0;
      asmb    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (active) begin
        locked           <= 1'b1;
        rcnt             <= last ? '0 : cur + 1'b1;
        asmb[cur*W +: W] <= data_i;
        if (last) begin
          word_o  <= full;
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_link.sv
module tdm_link #(
  parameter int W       = 8,
  parameter int HARD    = 2,
  parameter int SOFT    = 4,
  parameter bit FAST_RX = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SOFT*HARD*W-1:0]  tx_word,
  output logic                    tx_load,
  output logic [W-1:0]            link_data,
  output logic                    link_mark,
  output logic [SOFT*HARD*W-1:0]  rx_word,
  output logic                    rx_valid,
  output logic                    rx_sys_en
);
  localparam int N   = SOFT * HARD;
  localparam int HCW = tdm_link_pkg::cnt_w(HARD);

  logic [HARD*W-1:0] soft_slot;
  logic              soft_first;
  logic [HCW-1:0]    hard_ph;
  logic [W-1:0]      in_data;
  logic              in_mark;

  tdm_tx_soft #(.W(W), .HARD(HARD), .SOFT(SOFT)) u_soft (
    .clk(clk), .rst(rst), .word_i(tx_word), .load_o(tx_load),
    .hard_ph_o(hard_ph), .slot_o(soft_slot), .first_o(soft_first)
  );

  tdm_tx_hard #(.W(W), .HARD(HARD)) u_hard (
    .clk(clk), .rst(rst), .slot_i(soft_slot), .first_i(soft_first),
    .hard_ph_i(hard_ph), .lane_o(link_data), .mark_o(link_mark)
  );

  if (FAST_RX) begin : g_rx_direct
    assign in_data = link_data;
    assign in_mark = link_mark;
  end else begin : g_rx_staged
    logic [W-1:0] data_q;
    logic         mark_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        data_q <= '0;
        mark_q <= 1'b0;
      end else begin
        data_q <= link_data;
        mark_q <= link_mark;
      end
    end
    assign in_data = data_q;
    assign in_mark = mark_q;
  end

  tdm_clk_en_div #(.DIV(HARD)) u_div (
    .clk(clk), .rst(rst), .sync_i(in_mark), .en_o(rx_sys_en)
  );

  tdm_rx_asm #(.W(W), .N(N)) u_asm (
    .clk(clk), .rst(rst), .data_i(in_data), .mark_i(in_mark),
    .word_o(rx_word), .valid_o(rx_valid)
  );
endmodule

// File: rtl/tdm_link_chk.sv
module tdm_link_chk #(
  parameter int W    = 8,
  parameter int HARD = 2,
  parameter int SOFT = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         tx_load,
  input logic [W-1:0] link_data,
  input logic         link_mark,
  input logic         rx_valid,
  input logic         rx_sys_en
);
  localparam int N = SOFT * HARD;

  int   lc;
  int   ec;
  logic seen_load;
  logic seen_en;
  logic seen_mark;

  always_ff @(posedge clk) begin
    if (rst) begin
      lc <= 0; ec <= 0;
      seen_load <= 1'b0; seen_en <= 1'b0; seen_mark <= 1'b0;
    end else begin
      lc <= tx_load ? 0 : ((lc < N) ? lc + 1 : lc);
      ec <= rx_sys_en ? 0 : ((ec < HARD) ? ec + 1 : ec);
      if (tx_load)   seen_load <= 1'b1;
      if (rx_sys_en) seen_en   <= 1'b1;
      if (link_mark) seen_mark <= 1'b1;
    end
  end

  AST_LOAD_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (tx_load && seen_load) |-> (lc == N - 1)); // R2
  AST_MARK_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> ##2 link_mark); // R4
  AST_MARK_ONLY_SLOT0: assert property (@(posedge clk) disable iff (rst)
    link_mark |-> $past(tx_load, 2)); // R4
  AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!seen_mark && !link_mark) |-> (link_data == '0)); // R3
  AST_SYS_EN_SPACING: assert property (@(posedge clk) disable iff (rst)
    (rx_sys_en && seen_en) |-> (ec == HARD - 1)); // R5
  AST_VALID_ON_SYS_EN: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> rx_sys_en); // R6
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && N > 1) |=> !rx_valid); // R6
  AST_QUIET_BEFORE_MARK: assert property (@(posedge clk) disable iff (rst)
    (rx_valid || rx_sys_en) |-> seen_mark); // R8
endmodule

bind tdm_link tdm_link_chk #(.W(W), .HARD(HARD), .SOFT(SOFT)) u_chk (
  .clk(clk), .rst(rst), .tx_load(tx_load), .link_data(link_data),
  .link_mark(link_mark), .rx_valid(rx_valid), .rx_sys_en(rx_sys_en)
);

// File: tb/tdm_link_tb_mon.sv
module tdm_link_tb_mon #(
  parameter int W    = 8,
  parameter int HARD = 2,
  parameter int SOFT = 4,
  parameter bit FAST = 1'b0
) (
  input logic                   clk,
  input logic                   rst,
  input logic [SOFT*HARD*W-1:0] tx_word,
  input logic                   tx_load,
  input logic [W-1:0]           link_data,
  input logic                   link_mark,
  input logic [SOFT*HARD*W-1:0] rx_word,
  input logic                   rx_valid,
  input logic                   rx_sys_en
);
  localparam int N   = SOFT * HARD;
  localparam int NW  = N * W;
  localparam int LAT = N + (FAST ? 2 : 3);

  int n_chk = 0;
  int n_bad = 0;

  logic [NW-1:0] wq[$];
  int            sq[$];
  logic [NW-1:0] cur_w, prev_w;
  int            cur_s, prev_s;
  int            rc, gap, nloads;
  bit            seen_en;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (H%0d S%0d F%0d) act=%0h exp=%0h", req, HARD, SOFT, FAST, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      wq.delete(); sq.delete();
      rc = 0; gap = 0; nloads = 0; seen_en = 0;
      cur_w = '0; prev_w = '0; cur_s = 0; prev_s = 0;
    end else begin
      rc++;
      // R3 / R4: lane content against the words loaded so far
      begin
        int k;
        logic [W-1:0] exp_d;
        bit exp_m;
        exp_d = '0; exp_m = 0;
        k = rc - cur_s - 2;
        if (nloads >= 1 && k >= 0 && k < N) begin
          exp_d = cur_w[k*W +: W]; exp_m = (k == 0);
        end else if (nloads >= 2 && (rc - prev_s - 2) < N) begin
          k = rc - prev_s - 2;
          exp_d = prev_w[k*W +: W]; exp_m = (k == 0);
        end
        chk(link_data == exp_d, "R3 lane slot", 64'(link_data), 64'(exp_d));
        chk(link_mark == exp_m, "R4 marker", 64'(link_mark), 64'(exp_m));
      end
      // R1 / R2: load timing
      if (tx_load) begin
        if (nloads == 0) chk(rc == N, "R1 first load cycle", 64'(rc), 64'(N));
        else             chk(rc - cur_s == N, "R2 load period", 64'(rc - cur_s), 64'(N));
        prev_w = cur_w; prev_s = cur_s;
        cur_w = tx_word; cur_s = rc; nloads++;
        wq.push_back(tx_word); sq.push_back(rc);
      end
      // R5: divided enable spacing
      gap++;
      if (rx_sys_en) begin
        if (seen_en) chk(gap == HARD, "R5 enable spacing", 64'(gap), 64'(HARD));
        seen_en = 1; gap = 0;
      end
      // R6 / R7 / R8: reassembled words
      if (rx_valid) begin
        if (wq.size() == 0) begin
          chk(0, "R8 valid without word", 64'(1), 64'(0));
        end else begin
          logic [NW-1:0] ew;
          int es;
          ew = wq.pop_front(); es = sq.pop_front();
          chk(rx_word == ew, "R6 word", 64'(rx_word), 64'(ew));
          chk(rc - es == LAT, "R7 latency", 64'(rc - es), 64'(LAT));
          chk(rx_sys_en, "R6 valid with enable", 64'(rx_sys_en), 64'(1));
        end
      end
    end
  end
endmodule

// File: tb/tdm_link_tb_top.sv
module tdm_link_tb_top;
  localparam int W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] tx_word = '0;
  int          mode = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  // stimulus changes just after each rising edge
  always @(posedge clk) begin
    #1;
    case (mode)
      0: begin
        logic [63:0] x;
        x = (tx_word == '0) ? 64'h9e3779b97f4a7c15 : tx_word;
        x ^= x << 13; x ^= x >> 7; x ^= x << 17;
        tx_word = x;
      end
      1: tx_word = '1;
      2: tx_word = ($countones(tx_word) != 1) ? 64'd1 : {tx_word[62:0], tx_word[63]};
      3: tx_word = '0;
      default: tx_word = (tx_word == 64'haaaaaaaaaaaaaaaa) ? 64'h5555555555555555 : 64'haaaaaaaaaaaaaaaa;
    endcase
  end

  logic        a_load, a_mark, a_valid, a_en;
  logic [7:0]  a_data;
  logic [63:0] a_word;
  logic        b_load, b_mark, b_valid, b_en;
  logic [7:0]  b_data;
  logic [63:0] b_word;
  logic        c_load, c_mark, c_valid, c_en;
  logic [7:0]  c_data;
  logic [31:0] c_word;

  tdm_link #(.W(W), .HARD(2), .SOFT(4), .FAST_RX(1'b0)) dut_i (
    .clk(clk), .rst(rst), .tx_word(tx_word), .tx_load(a_load), .link_data(a_data),
    .link_mark(a_mark), .rx_word(a_word), .rx_valid(a_valid), .rx_sys_en(a_en));
  tdm_link #(.W(W), .HARD(4), .SOFT(2), .FAST_RX(1'b1)) dut_fast_i (
    .clk(clk), .rst(rst), .tx_word(tx_word), .tx_load(b_load), .link_data(b_data),
    .link_mark(b_mark), .rx_word(b_word), .rx_valid(b_valid), .rx_sys_en(b_en));
  tdm_link #(.W(W), .HARD(1), .SOFT(4), .FAST_RX(1'b0)) dut_h1_i (
    .clk(clk), .rst(rst), .tx_word(tx_word[31:0]), .tx_load(c_load), .link_data(c_data),
    .link_mark(c_mark), .rx_word(c_word), .rx_valid(c_valid), .rx_sys_en(c_en));

  tdm_link_tb_mon #(.W(W), .HARD(2), .SOFT(4), .FAST(1'b0)) mon_a (
    .clk(clk), .rst(rst), .tx_word(tx_word), .tx_load(a_load), .link_data(a_data),
    .link_mark(a_mark), .rx_word(a_word), .rx_valid(a_valid), .rx_sys_en(a_en));
  tdm_link_tb_mon #(.W(W), .HARD(4), .SOFT(2), .FAST(1'b1)) mon_b (
    .clk(clk), .rst(rst), .tx_word(tx_word), .tx_load(b_load), .link_data(b_data),
    .link_mark(b_mark), .rx_word(b_word), .rx_valid(b_valid), .rx_sys_en(b_en));
  tdm_link_tb_mon #(.W(W), .HARD(1), .SOFT(4), .FAST(1'b0)) mon_c (
    .clk(clk), .rst(rst), .tx_word(tx_word[31:0]), .tx_load(c_load), .link_data(c_data),
    .link_mark(c_mark), .rx_word(c_word), .rx_valid(c_valid), .rx_sys_en(c_en));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    int c, b;
    c = n_chk + mon_a.n_chk + mon_b.n_chk + mon_c.n_chk;
    b = n_bad + mon_a.n_bad + mon_b.n_bad + mon_c.n_bad;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", c, b);
  endtask

  // R1: outputs at zero while reset is held
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk({a_load, a_mark, a_valid, a_en} == 4'b0, "R1 control outputs in reset",
          64'({a_load, a_mark, a_valid, a_en}), 64'(0));
      chk(a_data == '0 && a_word == '0, "R1 data outputs in reset", a_word, 64'(0));
    end
    @(posedge clk); #1 rst = 1'b0;
  endtask

  // R7 / R8: quiet start and the one-cycle latency difference
  task automatic t_start_latency();
    int first_a, first_b;
    first_a = 0; first_b = 0;
    for (int rc = 1; rc <= 30; rc++) begin
      @(negedge clk);
      if (rc <= 10) chk(!a_valid && !a_en, "R8 quiet before marker",
                        64'({a_valid, a_en}), 64'(0));
      if (a_valid && first_a == 0) first_a = rc;
      if (b_valid && first_b == 0) first_b = rc;
    end
    chk(first_a == 19, "R7 first valid FAST_RX=0", 64'(first_a), 64'(19));
    chk(first_b == 18, "R7 first valid FAST_RX=1", 64'(first_b), 64'(18));
    chk(first_a - first_b == 1, "R7 latency saving", 64'(first_a - first_b), 64'(1));
  endtask

  // R5: hard ratio 1 gives an enable on every cycle once locked
  task automatic t_ratio_one();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(c_en, "R5 ratio one enable", 64'(c_en), 64'(1));
    end
  endtask

  // R3 / R6: a data pattern held for a number of frames, judged by the monitors
  task automatic t_pattern(input int m, input int frames);
    mode = m;
    repeat (frames * 8) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    mode = 0;
    t_reset();
    t_start_latency();
    t_ratio_one();
    t_pattern(0, 20);
    t_pattern(1, 4);
    t_pattern(2, 10);
    t_pattern(4, 6);
    t_pattern(3, 3);
    mode = 0;
    t_reset();
    t_start_latency();
    t_pattern(0, 12);
    done = 1;
    summary();
    $finish;
  end
endmodule